// File: doc/BRIEF.md
# Multicycle Load/Store/ALU/Branch Processor Core

This block is a small processor core. It runs a subset of a classic 32-bit load/store instruction set: word load, word store, five register-to-register operations (add, subtract, and, or, set-on-less-than) and branch-if-equal. It has no pipeline. A control state machine steps one shared datapath through a sequence of steps for each instruction, and the opcode picks how many steps that instruction takes. The datapath holds a program counter, an instruction register, a memory-data register, two operand registers, an ALU result register, a 32-entry register file and a single ALU. One ALU does every addition, comparison and logical operation. This includes the program-counter increment and the branch-target sum.

One memory port serves both instruction fetches and data accesses. The address, write data and write enable leave the core. Read data comes back combinationally in the same cycle as the address. A write takes effect at the clock edge that ends the cycle in which the write enable is high. Reset is synchronous and active high.

Top module: `mcyc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core goes to the fetch step with PC = 0. The first cycle after reset presents address 0 on `mem_addr` with `mem_we` low.
- R2: In a fetch cycle, `mem_addr` equals PC and the returned word is latched as the instruction. PC then becomes PC + 4.
- R3: Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x2A computes add/sub/and/or/signed-less-than (1 or 0) of the registers at bits [25:21] and [20:16]. The result is written to the register at bits [15:11], and the instruction takes 4 cycles.
- R4: Opcode 0x23 reads the word at (register[25:21] + sign-extended bits [15:0]) in its 4th cycle and writes it to register [20:16] in its 5th. It takes 5 cycles.
- R5: Opcode 0x2B drives `mem_we` high for exactly its 4th cycle, with `mem_addr` = register[25:21] + sign-extended imm and `mem_wdata` = register[20:16]. It takes 4 cycles. `mem_we` is low in every other cycle.
- R6: Opcode 0x04 takes 3 cycles. If the registers at [25:21] and [20:16] are equal, the next fetch is at PC+4 + (sign-extended imm << 2). Otherwise it is at PC+4. Backward offsets work.
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: Any other opcode, or opcode 0x00 with any other funct, takes 2 cycles. It changes no register and no memory, and it leaves PC at PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 32 | Read data for the word at `mem_addr`, same cycle |
| mem_addr | output | 32 | Byte address, PC on fetch, computed address on data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe, high for one cycle per store |

## Verification
Every result of this core appears at the memory port at a fixed cycle offset from the fetch of its instruction. The fetch address appears in cycle 1 of an instruction. A store's address and data appear in its cycle 4. A load's address also appears in its cycle 4. The next instruction's fetch address appears exactly 2, 3, 4 or 5 cycles after the previous fetch, depending on the instruction. The bench keeps its own instruction-level model of registers and PC. It walks each instruction through that predicted cycle count and samples the port at the falling edge of each predicted cycle. A wrong cycle count or a wrong branch therefore shows up as a fetch-address miscompare. A wrong ALU, load or register-zero result shows up as a store-data miscompare.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_EXEC, ST_BRANCH,
    ST_LOAD, ST_STORE, ST_RWB, ST_LWB
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_t;

  typedef enum logic [1:0] {
    SB_REG, SB_FOUR, SB_IMM, SB_IMM_SH
  } srcb_t;

  typedef struct packed {
    logic    ir_we;
    logic    pc_inc;
    logic    pc_branch;
    logic    ab_we;
    logic    aluout_we;
    logic    mdr_we;
    logic    mem_we;
    logic    addr_from_alu;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mdr;
    logic    srca_reg;
    srcb_t   srcb;
    alu_fn_t fn;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic funct_known(input logic [5:0] f);
    return (f == FN_ADD) || (f == FN_SUB) || (f == FN_AND) ||
           (f == FN_OR)  || (f == FN_SLT);
  endfunction

  function automatic alu_fn_t funct_to_fn(input logic [5:0] f);
    case (f)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_fn_t fn,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (fn)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: return a + b;
    endcase
  endfunction

endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
  parameter int NREGS = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  logic [DW-1:0] regs [NREGS];

  // entry 0 is never written, reads of it are forced to zero (R7)
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  alu_fn_t       fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);
  assign y    = alu_eval(fn, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output state_t     state,
  output ctrl_t      c,
  output logic       op_known
);
  state_t nxt;

  assign op_known = ((opcode == OPC_RTYPE) && funct_known(funct)) ||
                    (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                    (opcode == OPC_BEQ);

  always_comb begin
    c   = '0;
    c.fn   = ALU_ADD;
    c.srcb = SB_REG;
    nxt = ST_FETCH;
    case (state)
      ST_FETCH: begin
        c.ir_we  = 1'b1;
        c.pc_inc = 1'b1;
        c.srcb   = SB_FOUR;
        nxt      = ST_DECODE;
      end
      ST_DECODE: begin
        c.ab_we     = 1'b1;
        c.aluout_we = 1'b1;
        c.srcb      = SB_IMM_SH;
        if (!op_known)                 nxt = ST_FETCH;
        else if (opcode == OPC_RTYPE)  nxt = ST_EXEC;
        else if (opcode == OPC_BEQ)    nxt = ST_BRANCH;
        else                           nxt = ST_ADDR;
      end
      ST_ADDR: begin
        c.srca_reg  = 1'b1;
        c.srcb      = SB_IMM;
        c.aluout_we = 1'b1;
        nxt = (opcode == OPC_LOAD) ? ST_LOAD : ST_STORE;
      end
      ST_EXEC: begin
        c.srca_reg  = 1'b1;
        c.fn        = funct_to_fn(funct);
        c.aluout_we = 1'b1;
        nxt = ST_RWB;
      end
      ST_BRANCH: begin
        c.srca_reg  = 1'b1;
        c.fn        = ALU_SUB;
        c.pc_branch = 1'b1;
      end
      ST_LOAD: begin
        c.addr_from_alu = 1'b1;
        c.mdr_we        = 1'b1;
        nxt = ST_LWB;
      end
      ST_STORE: begin
        c.addr_from_alu = 1'b1;
        c.mem_we        = 1'b1;
      end
      ST_RWB: begin
        c.rf_we     = 1'b1;
        c.rf_dst_rd = 1'b1;
      end
      ST_LWB: begin
        c.rf_we       = 1'b1;
        c.rf_from_mdr = 1'b1;
      end
      default: nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we
);
  localparam int RAW = $clog2(NREGS);

  state_t          state;
  ctrl_t           c;
  logic            op_known;
  logic [XLEN-1:0] pc, ir, mdr, a_r, b_r, alu_out;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [RAW-1:0]  rf_wa;
  logic [XLEN-1:0] alu_a, alu_b, alu_y;
  logic            alu_zero;
  logic            br_taken;
  logic [XLEN-1:0] imm_ext;

  mcyc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (ir[31:26]),
    .funct    (ir[5:0]),
    .state    (state),
    .c        (c),
    .op_known (op_known)
  );

  assign rf_wa = c.rf_dst_rd ? ir[11+RAW-1:11] : ir[16+RAW-1:16];
  assign rf_wd = c.rf_from_mdr ? mdr : alu_out;

  mcyc_regfile #(.NREGS(NREGS), .DW(XLEN)) u_rf (
    .clk (clk),
    .ra1 (ir[21+RAW-1:21]),
    .ra2 (ir[16+RAW-1:16]),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2),
    .we  (c.rf_we),
    .wa  (rf_wa),
    .wd  (rf_wd)
  );

  assign imm_ext = sext16(ir[15:0]);
  assign alu_a   = c.srca_reg ? a_r : pc;

  always_comb begin
    case (c.srcb)
      SB_FOUR:   alu_b = XLEN'(4);
      SB_IMM:    alu_b = imm_ext;
      SB_IMM_SH: alu_b = {imm_ext[XLEN-3:0], 2'b00};
      default:   alu_b = b_r;
    endcase
  end

  mcyc_alu #(.DW(XLEN)) u_alu (
    .fn   (c.fn),
    .a    (alu_a),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign br_taken = c.pc_branch && alu_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      ir      <= '0;
      mdr     <= '0;
      a_r     <= '0;
      b_r     <= '0;
      alu_out <= '0;
    end else begin
      if (c.ir_we)     ir      <= mem_rdata;
      if (c.pc_inc)    pc      <= alu_y;
      if (br_taken)    pc      <= alu_out;
      if (c.ab_we)     a_r     <= rf_rd1;
      if (c.ab_we)     b_r     <= rf_rd2;
      if (c.aluout_we) alu_out <= alu_y;
      if (c.mdr_we)    mdr     <= mem_rdata;
    end
  end

  assign mem_addr  = c.addr_from_alu ? alu_out : pc;
  assign mem_wdata = b_r;
  assign mem_we    = c.mem_we;
endmodule

module mcyc_core_chk
  import mcyc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input state_t          state,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] ir,
  input logic [XLEN-1:0] a_r,
  input logic [XLEN-1:0] alu_out,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_we,
  input logic            op_known,
  input logic            br_taken
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (state == ST_FETCH && pc == '0))
    else $error("core not in fetch at pc 0 after reset");

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pc == $past(pc) + XLEN'(4)))
    else $error("pc did not advance by 4 after fetch");

  assert_rtype_len_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RWB) |=> (state == ST_FETCH))
    else $error("register writeback not followed by fetch");

  assert_load_len_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LWB) |-> ($past(state, 4) == ST_FETCH))
    else $error("load did not span five cycles");

  assert_store_addr_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ir[31:26] == OPC_STORE && mem_addr == alu_out))
    else $error("write strobe outside a store access");

  assert_branch_not_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BRANCH && !br_taken) |=> (pc == $past(pc)))
    else $error("untaken branch moved pc");

  assert_branch_taken_R6: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc == $past(alu_out)))
    else $error("taken branch missed its target");

  assert_r0_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && ir[25:21] == 5'd0) |=> (a_r == '0))
    else $error("register 0 read nonzero");

  assert_unknown_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && !op_known) |=> (state == ST_FETCH && pc == $past(pc)))
    else $error("unknown instruction not skipped");
endmodule

bind mcyc_core mcyc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .state    (state),
  .pc       (pc),
  .ir       (ir),
  .a_r      (a_r),
  .alu_out  (alu_out),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .op_known (op_known),
  .br_taken (br_taken)
);

// File: tb/mcyc_core_test.sv
module mcyc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we;

  logic [31:0] mem [0:1023];
  string       why [0:1023];
  logic [31:0] gr  [0:31];
  logic [31:0] ipc;
  string       prev_tag;
  int          vectors = 0;
  int          miscompares = 0;
  int          at = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:2]];

  mcyc_core uut (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  localparam logic [31:0] VBASE = 32'd3584;
  localparam logic [31:0] OUTA  = 32'd4000;

  function automatic logic [31:0] enc_r(int rd, int rs, int rt, logic [5:0] f);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] ref_op(logic [5:0] f, logic [31:0] x, logic [31:0] y);
    logic [31:0] d;
    d = x + ~y + 32'd1;
    case (f)
      6'h20:   return x + y;
      6'h22:   return d;
      6'h24:   return x & y;
      6'h25:   return x | y;
      default: return (x[31] != y[31]) ? {31'd0, x[31]} : {31'd0, d[31]};
    endcase
  endfunction

  task automatic emit(logic [31:0] w, string tag);
    mem[at] = w;
    why[at] = tag;
    at++;
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s at pc %h: got %h expected %h", tag, what, ipc, act, exp);
    end
  endtask

  task automatic step();
    logic [31:0] w, simm, ea;
    logic [5:0]  op, f;
    int          rs, rt, rd, n, kind;
    string       tg;
    w    = mem[ipc[11:2]];
    tg   = why[ipc[11:2]];
    op   = w[31:26];
    f    = w[5:0];
    rs   = int'(w[25:21]);
    rt   = int'(w[20:16]);
    rd   = int'(w[15:11]);
    simm = {{16{w[15]}}, w[15:0]};
    ea   = gr[rs] + simm;
    kind = 0;
    if (op == 6'h00 && (f == 6'h20 || f == 6'h22 || f == 6'h24 || f == 6'h25 || f == 6'h2A)) kind = 1;
    else if (op == 6'h23) kind = 2;
    else if (op == 6'h2B) kind = 3;
    else if (op == 6'h04) kind = 4;
    n = (kind == 0) ? 2 : (kind == 4) ? 3 : (kind == 2) ? 5 : 4;
    chk(mem_addr == ipc, prev_tag, "fetch address", mem_addr, ipc);
    chk(mem_we == 1'b0, "R5", "strobe during fetch", 32'(mem_we), 32'd0);
    for (int cyc = 2; cyc <= n; cyc++) begin
      @(negedge clk);
      if (kind == 3 && cyc == 4) begin
        chk(mem_we == 1'b1, "R5", "store strobe", 32'(mem_we), 32'd1);
        chk(mem_addr == ea, "R5", "store address", mem_addr, ea);
        chk(mem_wdata == gr[rt], tg, "store data", mem_wdata, gr[rt]);
      end else begin
        chk(mem_we == 1'b0, "R5", "idle strobe", 32'(mem_we), 32'd0);
        if (kind == 2 && cyc == 4) chk(mem_addr == ea, "R4", "load address", mem_addr, ea);
      end
    end
    ipc = ipc + 32'd4;
    case (kind)
      1: if (rd != 0) gr[rd] = ref_op(f, gr[rs], gr[rt]);
      2: if (rt != 0) gr[rt] = mem[ea[11:2]];
      4: if (gr[rs] == gr[rt]) ipc = ipc + {simm[29:0], 2'b00};
      default: ;
    endcase
    prev_tag = tg;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] vals [6];
    logic [5:0]  fns  [5];
    logic [31:0] halt_pc;
    vals = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h12345678};
    fns  = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    for (int k = 0; k < 1024; k++) begin
      mem[k] = 32'hFC00_0000;
      why[k] = "R8";
    end
    for (int k = 0; k < 6; k++) mem[896 + k] = vals[k];
    mem[902] = OUTA;
    mem[903] = 32'd1;
    mem[904] = 32'd3;
    mem[998] = 32'hCAFEF00D;
    for (int k = 0; k < 32; k++) gr[k] = 32'd0;

    // R3: sweep every operation over all operand pairs, store each result
    for (int i = 0; i < 6; i++) begin
      emit(enc_i(6'h23, 1, 0, int'(VBASE) + 4 * i), "R4");
      for (int j = 0; j < 6; j++) begin
        emit(enc_i(6'h23, 2, 0, int'(VBASE) + 4 * j), "R4");
        for (int q = 0; q < 5; q++) begin
          emit(enc_r(3, 1, 2, fns[q]), "R3");
          emit(enc_i(6'h2B, 3, 0, int'(OUTA)), "R3");
        end
      end
    end
    // R7: write to register 0 is dropped
    emit(enc_r(0, 1, 2, 6'h20), "R7");
    emit(enc_i(6'h2B, 0, 0, int'(OUTA)), "R7");
    // R4: negative offset load through a base register
    emit(enc_i(6'h23, 5, 0, int'(VBASE) + 24), "R4");
    emit(enc_i(6'h23, 6, 5, -8), "R4");
    emit(enc_i(6'h2B, 6, 5, 4), "R4");
    // R6: taken forward branch skips two stores
    emit(enc_i(6'h04, 0, 0, 2), "R6");
    emit(enc_i(6'h2B, 1, 0, int'(OUTA)), "R6");
    emit(enc_i(6'h2B, 2, 0, int'(OUTA)), "R6");
    // R6: untaken branch
    emit(enc_i(6'h04, 6, 0, 5), "R6");
    // R6: backward loop counting 3 down to 0
    emit(enc_i(6'h23, 8, 0, int'(VBASE) + 28), "R4");
    emit(enc_i(6'h23, 7, 0, int'(VBASE) + 32), "R4");
    emit(enc_r(7, 7, 8, 6'h22), "R6");
    emit(enc_i(6'h04, 0, 7, 1), "R6");
    emit(enc_i(6'h04, 0, 0, -3), "R6");
    emit(enc_i(6'h2B, 7, 0, int'(OUTA)), "R6");
    // R8: unknown opcode and unknown funct leave r3 as it was
    emit(enc_i(6'h08, 3, 1, 17), "R8");
    emit(enc_r(3, 1, 2, 6'h21), "R8");
    emit(enc_i(6'h2B, 3, 0, int'(OUTA)), "R8");
    halt_pc = 32'(at * 4);
    emit(enc_i(6'h04, 0, 0, -1), "R6");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_we == 1'b0, "R1", "strobe in reset", 32'(mem_we), 32'd0);
    rst = 1'b0;
    ipc = 32'd0;
    prev_tag = "R1";
    while (ipc != halt_pc) step();
    chk(mem_addr == halt_pc, prev_tag, "final fetch address", mem_addr, halt_pc);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not reach halt, got %0d expected 0 cycles left", 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule